// File: doc/BRIEF.md
# Per-Bit Sampler Offset Calibrator

This block centres the receive samplers of one byte lane. The lane must be idle while it runs, so the receivers see the mid-rail level. A sweep applies one 4-bit sampler offset code to every bit of the lane at the same time. The code steps through every value from 1 to 15. At each step the block raises a training strobe together with a forced-termination request. It waits a programmable settling time and then captures the per-bit feedback from the samplers.

While the sweep runs, the block keeps two trackers for each bit. One holds the lowest code at which that bit read 0. The other holds the highest code at which that bit read 1. After the last code it takes the midpoint of the two trackers for each bit. It forces any bit that never changed to a rail value and packs the results, four bits per lane bit, into one result word. A low-power DRAM mode adds a ninth bit, the strobe sampler. That bit is trained in the same way and its centre is reported on a separate output.

Top module: `samp_offset_cal`

## Requirements
- R1: After reset, done, train_mode and odt_force are low, and offset_word, result_word and strobe_ctr are all zero.
- R2: A start pulse seen while idle begins a sweep of codes 1, 2, ..., 15 in ascending order. While a code is applied, every 4-bit field of offset_word holds that code, with lane bit i using bits [4i+3:4i]. offset_word is zero while idle.
- R3: For each code, train_mode and odt_force rise together and stay high for SETTLE_CYC+1 cycles. Feedback is captured on the last of those cycles. Both signals are then low for exactly one cycle before the next code's pulse, and the code changes while they are low.
- R4: For each bit, a captured 1 sets that bit's high tracker to the current code. A captured 0 sets the low tracker to the current code only if the low tracker still holds 0. Both trackers are cleared to 0 when a sweep starts.
- R5: Each bit's centre is the integer half of the sum of its low and high trackers, limited to 15.
- R6: A bit whose low tracker is still 0 after the sweep gets centre 15. A bit whose high tracker is still 0 gets centre 0, and this second rule wins when both apply.
- R7: result_word holds the centre of lane bit i in bits [4i+3:4i].
- R8: With lp_mode high at start, feedback[8] is trained as the strobe bit and its centre appears on strobe_ctr. With lp_mode low, feedback[8] has no effect and strobe_ctr reads 0.
- R9: done is a one-cycle pulse, high after the 15*(SETTLE_CYC+2)-th rising edge that follows the edge which accepted start. result_word and strobe_ctr become valid with done and hold until the next sweep ends.
- R10: A start pulse during a sweep is ignored. Feedback while train_mode is low has no effect on the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sweep (accepted only when idle) |
| lp_mode | input | 1 | Also train the ninth (strobe) bit |
| offset_word | output | 32 | Sampler offset codes, 4 bits per lane bit |
| train_mode | output | 1 | Sampler training strobe |
| odt_force | output | 1 | Forced termination request during training |
| feedback | input | 9 | Per-bit sampler output; bit 8 is the strobe sampler |
| result_word | output | 32 | Trained centres, 4 bits per lane bit |
| strobe_ctr | output | 4 | Trained centre of the strobe bit |
| done | output | 1 | One-cycle completion pulse |

## Verification
Once the start edge is accepted, the cycle count of a sweep is fixed. done must therefore appear after exactly 15*(SETTLE_CYC+2) rising edges. The bench counts edges from the accepting edge and compares done at the falling edge after each one. It expects done only at that count and reads the results in the same half-cycle. Feedback is modelled as a function of the applied code while train_mode is high and as random noise while it is low. This makes each capture independent of the exact sample edge inside the pulse and checks that captures occur only inside it. The code and pulse order are checked at every rise of train_mode, and the held results are read again two cycles after done.

// File: rtl/samp_offset_cal.sv
module samp_offset_cal #(
  parameter int NBITS      = 8,
  parameter int CODE_W     = 4,
  parameter int SETTLE_CYC = 100
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      lp_mode,
  output logic [NBITS*CODE_W-1:0]   offset_word,
  output logic                      train_mode,
  output logic                      odt_force,
  input  logic [NBITS:0]            feedback,
  output logic [NBITS*CODE_W-1:0]   result_word,
  output logic [CODE_W-1:0]         strobe_ctr,
  output logic                      done
);
  localparam int NTRK     = NBITS + 1;
  localparam int CODE_MAX = (1 << CODE_W) - 1;
  localparam int CNT_W    = $clog2(SETTLE_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETTLE, S_SAMPLE, S_GAP, S_CALC} st_t;
  st_t state;

  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              lp_q;
  logic              train_q;
  logic [CODE_W-1:0] fz_q [NTRK];
  logic [CODE_W-1:0] lo_q [NTRK];
  logic [CODE_W-1:0] ctr  [NTRK];

  wire accept = (state == S_IDLE) && start;
  wire last_code = (code_q == CODE_W'(CODE_MAX));

  assign offset_word = (state == S_IDLE) ? '0 : {NBITS{code_q}};
  assign train_mode  = train_q;
  assign odt_force   = train_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      code_q  <= '0;
      cnt_q   <= '0;
      lp_q    <= 1'b0;
      train_q <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          state   <= S_SETTLE;
          code_q  <= CODE_W'(1);
          cnt_q   <= '0;
          lp_q    <= lp_mode;
          train_q <= 1'b1;
        end
        S_SETTLE: begin
          if (cnt_q == CNT_W'(SETTLE_CYC - 1)) state <= S_SAMPLE;
          else cnt_q <= cnt_q + 1'b1;
        end
        S_SAMPLE: begin
          train_q <= 1'b0;
          if (last_code) state <= S_CALC;
          else begin
            state  <= S_GAP;
            code_q <= code_q + 1'b1;
          end
        end
        S_GAP: begin
          state   <= S_SETTLE;
          cnt_q   <= '0;
          train_q <= 1'b1;
        end
        S_CALC: begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NTRK; g++) begin : g_trk
    wire live = (g < NBITS) || lp_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fz_q[g] <= '0;
        lo_q[g] <= '0;
      end else if (accept) begin
        fz_q[g] <= '0;
        lo_q[g] <= '0;
      end else if (state == S_SAMPLE && live) begin
        if (feedback[g]) lo_q[g] <= code_q;
        else if (fz_q[g] == '0) fz_q[g] <= code_q;
      end
    end

    logic [CODE_W:0] sum;
    logic [CODE_W:0] half;
    assign sum  = {1'b0, fz_q[g]} + {1'b0, lo_q[g]};
    assign half = sum >> 1;
    always_comb begin
      ctr[g] = (half > (CODE_W+1)'(CODE_MAX)) ? CODE_W'(CODE_MAX) : half[CODE_W-1:0];
      if (fz_q[g] == '0) ctr[g] = CODE_W'(CODE_MAX);
      if (lo_q[g] == '0) ctr[g] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_word <= '0;
      strobe_ctr  <= '0;
    end else if (state == S_CALC) begin
      for (int i = 0; i < NBITS; i++) result_word[i*CODE_W +: CODE_W] <= ctr[i];
      strobe_ctr <= lp_q ? ctr[NBITS] : '0;
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  train_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !train_mode && !odt_force);

  // R2
  code_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    train_mode |-> offset_word[CODE_W-1:0] != '0);

  // R2
  code_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(train_mode) && (state != S_IDLE) && $past(state) == S_GAP
      |-> offset_word[CODE_W-1:0] == $past(offset_word[CODE_W-1:0]));

  // R3
  gap_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(train_mode) && (state == S_GAP) |=> train_mode);

  // R8
  strobe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !lp_q |-> strobe_ctr == '0);

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SETTLE) && start |=> state != S_IDLE);
endmodule

// File: tb/tb_samp_offset_cal.sv
module tb_samp_offset_cal;
  localparam int S     = 100;
  localparam int TOTAL = 15 * (S + 2);

  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic        lp_mode = 0;
  logic [31:0] offset_word;
  logic        train_mode, odt_force;
  logic [8:0]  feedback;
  logic [31:0] result_word;
  logic [3:0]  strobe_ctr;
  logic        done;

  logic [15:0] resp [9];
  logic [8:0]  noise = '0;
  int tests = 0, fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  samp_offset_cal #(.NBITS(8), .CODE_W(4), .SETTLE_CYC(S)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .lp_mode(lp_mode),
    .offset_word(offset_word), .train_mode(train_mode), .odt_force(odt_force),
    .feedback(feedback), .result_word(result_word), .strobe_ctr(strobe_ctr),
    .done(done));

  always_comb
    for (int b = 0; b < 9; b++)
      feedback[b] = train_mode ? resp[b][offset_word[3:0]] : noise[b];

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic logic [3:0] exp_ctr(logic [15:0] r);
    int fz = 0, lo = 0, s;
    for (int c = 1; c <= 15; c++) begin
      if (r[c]) lo = c;
      else if (fz == 0) fz = c;
    end
    s = (fz + lo) / 2;
    if (s > 15) s = 15;
    if (fz == 0) s = 15;
    if (lo == 0) s = 0;
    return 4'(s);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] make_resp(int kind);
    int t = $urandom_range(1, 16);
    logic [15:0] r = '0;
    for (int c = 0; c < 16; c++)
      case (kind)
        0: r[c] = (c < t);
        1: r[c] = 1'($urandom);
        2: r[c] = 1'b1;
        3: r[c] = 1'b0;
        default: r[c] = (c >= t);
      endcase
    return r;
  endfunction

  task automatic run_sweep(bit lp, bit poke);
    int rises = 0, gaps = 0, done_at = -1, ndone = 0, low_run = 0;
    bit code_ok = 1, uni_ok = 1, prev_tr = 0;
    @(negedge clk);
    lp_mode = lp;
    start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    lp_mode = 1'($urandom);
    for (int k = 1; k <= TOTAL + 2; k++) begin
      @(negedge clk);
      noise = 9'($urandom);
      start = poke && (k == 50);
      if (train_mode && !prev_tr) begin
        rises++;
        if (offset_word[3:0] != 4'(rises)) code_ok = 0;
        for (int b = 1; b < 8; b++)
          if (offset_word[4*b +: 4] != offset_word[3:0]) uni_ok = 0;
        if (rises > 1 && low_run != 1) gaps++;
      end
      if (!train_mode) low_run++; else low_run = 0;
      if (train_mode != odt_force) uni_ok = 0;
      prev_tr = train_mode;
      if (done) begin ndone++; done_at = k; end
      if (k == TOTAL) begin
        for (int b = 0; b < 8; b++)
          chk(result_word[4*b +: 4] == exp_ctr(resp[b]), "R4/R5/R6/R7 bit centre",
              result_word[4*b +: 4], exp_ctr(resp[b]));
        chk(strobe_ctr == (lp ? exp_ctr(resp[8]) : 4'd0), "R8 strobe centre",
            strobe_ctr, lp ? exp_ctr(resp[8]) : 0);
      end
      if (k == TOTAL + 2) begin
        logic [31:0] ew = '0;
        for (int b = 0; b < 8; b++) ew[4*b +: 4] = exp_ctr(resp[b]);
        chk(result_word == ew && !done && offset_word == 0, "R9 results held",
            result_word, ew);
      end
    end
    start = 0;
    chk(ndone == 1 && done_at == TOTAL, "R9 done timing (R10 start ignored)", done_at, TOTAL);
    chk(rises == 15 && code_ok, "R2 code order", rises, 15);
    chk(uni_ok, "R2 replicated fields", uni_ok, 1);
    chk(gaps == 0, "R3 one-cycle gap", gaps, 0);
  endtask

  initial begin
    void'($urandom(32'h5A17));
    for (int b = 0; b < 9; b++) resp[b] = '0;
    #23;
    chk(done == 0 && train_mode == 0 && odt_force == 0 && offset_word == 0 &&
        result_word == 0 && strobe_ctr == 0, "R1 reset state", result_word, 0);
    rst_n = 1;
    // directed: saturations R6
    for (int b = 0; b < 9; b++) resp[b] = make_resp(b % 2 ? 2 : 3);
    run_sweep(1, 0);
    for (int b = 0; b < 9; b++) resp[b] = make_resp(0);
    run_sweep(0, 1);
    for (int b = 0; b < 9; b++) resp[b] = make_resp(4);
    run_sweep(1, 1);
    for (int n = 0; n < 14; n++) begin
      for (int b = 0; b < 9; b++) resp[b] = make_resp($urandom_range(0, 4));
      run_sweep(1'($urandom), 1'($urandom));
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule